// File: doc/BRIEF.md
# Dithered PWM Level Generator

This block drives a single LED channel from a 15-bit brightness word. The upper eight bits of the word set a base duty for an 8-bit pulse-width modulator. The lower seven bits are a fraction. A first-order delta-sigma loop turns that fraction into an occasional one-step increase of the duty. Averaged over many periods, the light output therefore has about 15 bits of resolution, although the counter itself only resolves eight.

A 512-cycle period counter runs freely. At every period boundary the duty computed in the previous period is moved into the compare register. The next duty is computed only after that move, so each dithered duty is used one period after it is computed. A level write puts the new base duty on the output at once and turns on the regulator enable. If the channel was off before the write, the write also restarts the period phase. An off command blanks the channel and stops the dither loop.

Top module: `dpwm_level_gen`

## Requirements
- R1: While reset is held, and directly after it is released, `pwm_o` and `drv_en_o` are low.
- R2: The base duty is `level_i[14:7]`, an integer from 0 to 255. A period is 512 clocks, numbered by a phase from 0 to 511. `pwm_o` is high in each cycle whose phase divided by two (rounded down) is below the active duty, so it is high for two clocks per duty step, starting at phase 0.
- R3: Once per period, the fraction `level_i[6:0]` is added to a 7-bit accumulator. If the sum is above 127, the next duty is the base duty plus one; otherwise it is the base duty. The accumulator then keeps the low seven bits of the sum.
- R4: At each period boundary, the duty computed at the previous boundary becomes active. A newly computed duty therefore first shows in the period after the one that starts at that boundary.
- R5: A level write (`level_wr_i` high, `off_i` low) makes the new base duty active on the very next clock. The same write sets `drv_en_o` high and arms the per-period dither. This holds for a level of 0 as well, which gives a high enable and a low output.
- R6: A level write while the channel is off restarts the phase at 0. A level write while the channel is on leaves both the phase and the accumulator unchanged.
- R7: `off_i` clears the level, the active duty, the pending duty and the accumulator. It restarts the phase and lowers `drv_en_o`. `pwm_o` stays low until the next level write.
- R8: A base duty of 255 with a carry gives a duty of 256. That duty holds `pwm_o` high for all 512 clocks of the period and does not wrap to zero.
- R9: When `off_i` and `level_wr_i` are high in the same cycle, the off command wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_i | input | 15 | Brightness word: base duty in bits 14:7, fraction in bits 6:0 |
| level_wr_i | input | 1 | One-cycle strobe that loads `level_i` |
| off_i | input | 1 | One-cycle command that turns the channel off |
| pwm_o | output | 1 | Dithered PWM output |
| drv_en_o | output | 1 | Enable for the current regulator |

## Verification
The bench drives the block with a set of directed levels and checks every clock against a cycle-level reference built from the requirements:
- A zero fraction must give the same pulse width in every period.
- Fractions of 64, 127 and 5 give different carry patterns. These patterns expose a wrong carry threshold and a missing or doubled period of latency.
- A write in the middle of a period, while the channel is on, tells phase and accumulator retention apart from a restart.
- A write after an off, made at a free-running phase that is not zero, shows that the phase restarts.
- Level 255/127 tests saturation at full on.
- Level 0, the off command, and an off coinciding with a write test the blanking and priority rules.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int BASE_W_DEF = 8;  // hardware duty resolution
  localparam int FRAC_W_DEF = 7;  // dither fraction width
  localparam int PRE_W_DEF  = 1;  // extra counter bits: period = 2**(BASE_W+PRE_W)
endpackage

// File: rtl/dpwm_phase_counter.sv
module dpwm_phase_counter #(
  parameter int BASE_W = dpwm_pkg::BASE_W_DEF,
  parameter int PRE_W  = dpwm_pkg::PRE_W_DEF,
  localparam int CNT_W = BASE_W + PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  output logic [BASE_W-1:0] slot_o,
  output logic              wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign slot_o = cnt_q[CNT_W-1:PRE_W];
  assign wrap_o = &cnt_q;

  // R6: a clear request always restarts the period at phase zero
  assert_clear_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither #(
  parameter int BASE_W = dpwm_pkg::BASE_W_DEF,
  parameter int FRAC_W = dpwm_pkg::FRAC_W_DEF,
  localparam int LVL_W  = BASE_W + FRAC_W,
  localparam int DUTY_W = BASE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [BASE_W-1:0] load_base_i,
  input  logic              step_i,
  input  logic [LVL_W-1:0]  level_i,
  output logic [DUTY_W-1:0] next_duty_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic              carry;

  function automatic logic [FRAC_W:0] err_add(input logic [FRAC_W-1:0] acc,
                                              input logic [FRAC_W-1:0] frac);
    return {1'b0, acc} + {1'b0, frac};
  endfunction

  function automatic logic [DUTY_W-1:0] duty_of(input logic [BASE_W-1:0] base,
                                                input logic c);
    return {1'b0, base} + DUTY_W'(c);
  endfunction

  assign sum   = err_add(acc_q, level_i[FRAC_W-1:0]);
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      acc_q       <= '0;
      next_duty_o <= '0;
    end else if (load_i) begin
      next_duty_o <= {1'b0, load_base_i};
    end else if (step_i) begin
      next_duty_o <= duty_of(level_i[LVL_W-1:FRAC_W], carry);
      acc_q       <= sum[FRAC_W-1:0];
    end
  end

  // R3: the pending duty never strays from the stored base by more than one step
  assert_dither_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (next_duty_o >= {1'b0, level_i[LVL_W-1:FRAC_W]}) &&
    (next_duty_o <= {1'b0, level_i[LVL_W-1:FRAC_W]} + 1'b1));
endmodule

// File: rtl/dpwm_compare.sv
module dpwm_compare #(
  parameter int BASE_W = dpwm_pkg::BASE_W_DEF,
  localparam int DUTY_W = BASE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [BASE_W-1:0] load_base_i,
  input  logic              step_i,
  input  logic [DUTY_W-1:0] next_duty_i,
  input  logic [BASE_W-1:0] slot_i,
  input  logic              on_i,
  output logic              pwm_o
);
  localparam logic [DUTY_W-1:0] FULL = DUTY_W'(1) << BASE_W;
  logic [DUTY_W-1:0] duty_q;

  function automatic logic lit(input logic [BASE_W-1:0] slot,
                               input logic [DUTY_W-1:0] duty);
    return ({1'b0, slot} < duty);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) duty_q <= '0;
    else if (load_i)     duty_q <= {1'b0, load_base_i};
    else if (step_i)     duty_q <= next_duty_i;
  end

  assign pwm_o = on_i & lit(slot_i, duty_q);

  // R8: the active duty tops out at full-on and never wraps
  assert_duty_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    duty_q <= FULL);
  // R4: the active duty changes only at a boundary, a write or an off
  assert_duty_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_i && !step_i) |=> $stable(duty_q));
  // R7: no output pulse while the channel is off
  assert_dark_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !on_i |-> !pwm_o);
endmodule

// File: rtl/dpwm_level_gen.sv
module dpwm_level_gen #(
  parameter int BASE_W = dpwm_pkg::BASE_W_DEF,
  parameter int FRAC_W = dpwm_pkg::FRAC_W_DEF,
  parameter int PRE_W  = dpwm_pkg::PRE_W_DEF,
  localparam int LVL_W  = BASE_W + FRAC_W,
  localparam int DUTY_W = BASE_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_i,
  input  logic             level_wr_i,
  input  logic             off_i,
  output logic             pwm_o,
  output logic             drv_en_o
);
  logic              on_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [BASE_W-1:0] slot;
  logic              wrap;
  logic [DUTY_W-1:0] next_duty;

  // named events for the assertions
  logic do_load, phase_clr, dither_step;
  assign do_load     = level_wr_i & ~off_i;                 // R9: off wins
  assign phase_clr   = off_i | (do_load & ~on_q);
  assign dither_step = on_q & wrap & ~off_i & ~do_load;

  always_ff @(posedge clk) begin
    if (!rst_n || off_i) begin
      on_q  <= 1'b0;
      lvl_q <= '0;
    end else if (do_load) begin
      on_q  <= 1'b1;
      lvl_q <= level_i;
    end
  end

  assign drv_en_o = on_q;

  dpwm_phase_counter #(.BASE_W(BASE_W), .PRE_W(PRE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear_i(phase_clr), .slot_o(slot), .wrap_o(wrap));

  dpwm_dither #(.BASE_W(BASE_W), .FRAC_W(FRAC_W)) u_dith (
    .clk(clk), .rst_n(rst_n), .clr_i(off_i), .load_i(do_load),
    .load_base_i(level_i[LVL_W-1:FRAC_W]), .step_i(dither_step),
    .level_i(lvl_q), .next_duty_o(next_duty));

  dpwm_compare #(.BASE_W(BASE_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr_i(off_i), .load_i(do_load),
    .load_base_i(level_i[LVL_W-1:FRAC_W]), .step_i(dither_step),
    .next_duty_i(next_duty), .slot_i(slot), .on_i(on_q), .pwm_o(pwm_o));

  assert_write_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> drv_en_o);
  assert_off_blanks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    off_i |=> (!drv_en_o && !pwm_o));
  assert_off_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (off_i && level_wr_i) |=> !drv_en_o);
  assert_wake_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_load && !drv_en_o) |=> (slot == '0));
endmodule

// File: tb/sim_dpwm_level_gen.sv
`timescale 1ns/1ps
module sim_dpwm_level_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [14:0] level_i = '0;
  logic level_wr_i = 1'b0;
  logic off_i = 1'b0;
  logic pwm_o, drv_en_o;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state, written from the requirements
  bit m_on;
  int m_lvl, m_cmp, m_nxt, m_cnt, m_acc;

  always #4 clk = ~clk;

  dpwm_level_gen u0 (.clk(clk), .rst_n(rst_n), .level_i(level_i),
    .level_wr_i(level_wr_i), .off_i(off_i), .pwm_o(pwm_o), .drv_en_o(drv_en_o));

  task automatic check(input string tag);
    bit ep;
    ep = m_on && ((m_cnt / 2) < m_cmp);
    vectors++;
    if (pwm_o !== ep || drv_en_o !== m_on) begin
      fails++;
      $display("FAIL %s phase %0d: pwm=%b exp=%b en=%b exp=%b",
               tag, m_cnt, pwm_o, ep, drv_en_o, m_on);
    end
  endtask

  // one clock: drive, advance reference, compare
  task automatic step(input bit off, input bit wr, input int lvl, input string tag);
    int s;
    off_i = off; level_wr_i = wr; level_i = 15'(lvl);
    @(posedge clk);
    if (off) begin
      m_on = 0; m_lvl = 0; m_cmp = 0; m_nxt = 0; m_acc = 0; m_cnt = 0;
    end else if (wr) begin
      m_cnt = m_on ? (m_cnt + 1) % 512 : 0;
      m_on = 1; m_lvl = lvl; m_cmp = lvl / 128; m_nxt = lvl / 128;
    end else begin
      if (m_on && m_cnt == 511) begin
        m_cmp = m_nxt;
        s = m_acc + (m_lvl % 128);
        m_nxt = (m_lvl / 128) + (s > 127 ? 1 : 0);
        m_acc = s % 128;
      end
      m_cnt = (m_cnt + 1) % 512;
    end
    @(negedge clk);
    off_i = 0; level_wr_i = 0;
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  task automatic t_reset;
    m_on = 0; m_lvl = 0; m_cmp = 0; m_nxt = 0; m_cnt = 0; m_acc = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    idle(4, "R1 after reset");
  endtask

  task automatic t_flat;      // R2: no fraction, same width every period
    step(0, 1, (100 << 7), "R2 write");
    idle(3 * 512, "R2 flat duty");
  endtask

  task automatic t_half_mid;  // R3 R4 R6: write on the fly, phase and acc kept
    idle(200, "R6 idle");
    step(0, 1, (40 << 7) | 64, "R6 write while on");
    idle(6 * 512, "R3 R4 frac 64");
  endtask

  task automatic t_frac_hi;
    step(0, 1, (10 << 7) | 127, "R5 write");
    idle(8 * 512, "R3 frac 127");
    step(0, 1, (7 << 7) | 5, "R5 write");
    idle(6 * 512, "R3 frac 5");
  endtask

  task automatic t_off;       // R7
    idle(77, "R7 pre");
    step(1, 0, 0, "R7 off");
    idle(2 * 512 + 33, "R7 dark");
  endtask

  task automatic t_wake;      // R6: phase restart from off at nonzero phase
    step(0, 1, (200 << 7) | 33, "R6 wake");
    idle(3 * 512, "R6 wake run");
  endtask

  task automatic t_sat;       // R8
    step(0, 1, (255 << 7) | 127, "R8 write");
    idle(5 * 512, "R8 saturate");
  endtask

  task automatic t_zero;      // R5: level zero enables but stays dark
    step(0, 1, 0, "R5 zero level");
    idle(600, "R5 zero run");
  endtask

  task automatic t_priority;  // R9
    step(1, 1, (90 << 7) | 3, "R9 off+write");
    idle(300, "R9 stays off");
  endtask

  initial begin
    t_reset();
    t_flat();
    t_half_mid();
    t_frac_hi();
    t_off();
    t_wake();
    t_sat();
    t_zero();
    t_priority();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule